// File: doc/BRIEF.md
# Oversampled UART Receiver with Mute and Wakeup

This block receives asynchronous serial frames from a single RX line that is sampled at a fixed multiple of the baud rate. A frame is one low start bit, 8 or 9 word bits sent least significant bit first, and one stop bit. The block confirms the start bit, samples each bit in its middle and presents the received word on a held data-ready flag until the consumer acknowledges it. It can replace the top bit of the word with an even or odd parity bit and check it, and it reports framing and overrun errors.

A mute feature lets several receivers share one line. A muted receiver keeps decoding frames but delivers nothing and raises no flags. It returns to active mode in one of two ways, chosen by configuration. In idle-line mode it wakes after one frame time of continuous high level. In address mode it wakes on a word whose top data bit is set and whose low bits equal the node address. An address word that does not match puts the receiver back into mute.

Configuration that shapes the frame (word length, parity on/off, parity sense, wake method) is copied into the block only while it is disabled. A single interrupt line combines the data and error conditions under two enables.

Top module: `uart_rx_mute`

## Requirements
- R1: With the block enabled, a frame is sampled at the middle of each bit, least significant bit first, with 8 bits when `cfg_len9_i`=0 and 9 bits when it is 1. On completion `data_o` holds the word and `rdy_o` is set, and both hold until `rx_ack_i` clears `rdy_o`. After reset all flags and `muted_o` are 0.
- R2: A low level on the line that has ended before the middle of the start bit does not start a frame.
- R3: With parity enabled, the top bit of the word (bit 8 for 9-bit words, bit 7 for 8-bit words) is the parity bit. `data_o` shows that bit as 0. `par_err_o` is set when the count of ones over all word bits, parity bit included, is odd under even parity (`cfg_par_odd_i`=0) or even under odd parity (`cfg_par_odd_i`=1).
- R4: A stop bit sampled low sets `frm_err_o` together with `rdy_o`.
- R5: If a word completes while `rdy_o` is set and not being acknowledged, `ovr_err_o` is set, `data_o` keeps the earlier word, and `rx_ack_i` clears `rdy_o`, `ovr_err_o`, `par_err_o` and `frm_err_o`.
- R6: The word length, parity enable, parity select and wake method inputs are copied only while `en_i` is 0. Changes made while it is 1 have no effect.
- R7: While `cfg_mute_en_i` is 0, `muted_o` is 0 and `mute_req_i` is ignored. While it is 1, a pulse on `mute_req_i` sets `muted_o`.
- R8: In idle-line wake mode (`cfg_wake_addr_i`=0), a muted receiver becomes active after a continuous high level lasting one frame time (word length plus 2 bit times).
- R9: In address wake mode (`cfg_wake_addr_i`=1), a word whose top data bit is 1 is an address. If its low 4 bits equal `cfg_node_i`, it clears `muted_o` and is delivered. Otherwise it sets `muted_o` (when mute is enabled) and is not delivered.
- R10: While muted, completed words do not set `rdy_o`, `par_err_o`, `frm_err_o` or `ovr_err_o`.
- R11: `irq_o` is 1 exactly when (`ie_rx_i` and (`rdy_o` or `ovr_err_o`)) or (`ie_par_i` and `par_err_o`).
- R12: While `en_i` is 0, frames on the line are not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| en_i | input | 1 | Receiver enable |
| cfg_len9_i | input | 1 | 1: 9-bit word, 0: 8-bit word |
| cfg_par_en_i | input | 1 | Parity check enable |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| cfg_mute_en_i | input | 1 | Allow mute mode |
| cfg_wake_addr_i | input | 1 | 1: address wake, 0: idle-line wake |
| cfg_node_i | input | 4 | Node address for address wake |
| mute_req_i | input | 1 | Pulse to enter mute mode |
| rx_ack_i | input | 1 | Acknowledge of received word |
| ie_rx_i | input | 1 | Interrupt enable for data ready or overrun |
| ie_par_i | input | 1 | Interrupt enable for parity error |
| data_o | output | 9 | Received word |
| rdy_o | output | 1 | Word available |
| par_err_o | output | 1 | Parity error of held word |
| frm_err_o | output | 1 | Framing error of held word |
| ovr_err_o | output | 1 | Overrun |
| muted_o | output | 1 | Receiver in mute mode |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is the series of mute transitions in address mode. The receiver has to be muted, ignore a plain word, wake on a matching address and deliver it, accept an ordinary word, and then fall back into mute on an address that does not match. All of this happens without a single unexpected word reaching the scoreboard. The stimulus forces mute through the request pin and then sends an ordered run of address and data words. The scoreboard holds only the words that should get through, so any extra delivery or any missed delivery shows up as a mismatch. Idle-line wake is reached by timing the high gap after a dropped frame, with `muted_o` checked before and after the frame-length threshold.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;

   typedef struct packed {
      logic len9;
      logic par_en;
      logic par_odd;
      logic wake_addr;
   } rx_cfg_t;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic              len_full_i,
   output logic [DATA_W-1:0] word_o,
   output logic              stop_ok_o,
   output logic              done_o,
   output logic              idle_o
);

   localparam int CNT_W     = $clog2(OVS);
   localparam int IDX_W     = $clog2(DATA_W + 1);
   localparam int FRAME_MAX = (DATA_W + 2) * OVS;
   localparam int IDLE_W    = $clog2(FRAME_MAX + 1);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end

   logic rx_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
      end
      assign rx_s = sync_q[SYNC_STAGES-1];
   end

   rx_state_e         st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  nbits;
   logic [IDLE_W-1:0] idle_cnt_q;
   logic [IDLE_W-1:0] frame_ticks;
   logic              prev_q;

   assign nbits       = len_full_i ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
   assign frame_ticks = len_full_i ? IDLE_W'(FRAME_MAX) : IDLE_W'(FRAME_MAX - OVS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         cnt_q      <= '0;
         idx_q      <= '0;
         idle_cnt_q <= '0;
         prev_q     <= 1'b1;
         word_o     <= '0;
         stop_ok_o  <= 1'b1;
         done_o     <= 1'b0;
         idle_o     <= 1'b0;
      end else begin
         done_o <= 1'b0;
         idle_o <= 1'b0;
         if (!en_i) begin
            st_q       <= RX_IDLE;
            cnt_q      <= '0;
            idle_cnt_q <= '0;
            prev_q     <= 1'b1;
         end else if (tick_i) begin
            prev_q <= rx_s;
            if (!rx_s) begin
               idle_cnt_q <= '0;
            end else if (idle_cnt_q < frame_ticks) begin
               idle_cnt_q <= idle_cnt_q + 1'b1;
               if (idle_cnt_q == frame_ticks - 1'b1) idle_o <= 1'b1;
            end
            unique case (st_q)
               RX_IDLE: begin
                  if (prev_q && !rx_s) begin
                     st_q  <= RX_START;
                     cnt_q <= '0;
                  end
               end
               RX_START: begin
                  if (cnt_q == CNT_W'(OVS / 2 - 1)) begin
                     cnt_q  <= '0;
                     idx_q  <= '0;
                     word_o <= '0;
                     st_q   <= rx_s ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt_q == CNT_W'(OVS - 1)) begin
                     cnt_q         <= '0;
                     word_o[idx_q] <= rx_s;
                     if (idx_q == nbits - 1'b1) st_q <= RX_STOP;
                     else                       idx_q <= idx_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == CNT_W'(OVS - 1)) begin
                     cnt_q     <= '0;
                     stop_ok_o <= rx_s;
                     done_o    <= 1'b1;
                     st_q      <= RX_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   a_r12_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (st_q == RX_IDLE && !done_o));

endmodule

// File: rtl/uart_rx_mute_ctl.sv
module uart_rx_mute_ctl #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mute_en_i,
   input  logic              wake_addr_i,
   input  logic              mute_req_i,
   input  logic              idle_i,
   input  logic              done_i,
   input  logic              is_addr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] node_i,
   output logic              deliver_o,
   output logic              muted_o
);

   logic addr_word;
   logic hit;

   assign addr_word = wake_addr_i && is_addr_i;
   assign hit       = addr_word && (addr_i == node_i);

   always_comb begin
      deliver_o = 1'b0;
      if (done_i) begin
         if (muted_o) deliver_o = hit;
         else         deliver_o = !(mute_en_i && addr_word && !hit);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         muted_o <= 1'b0;
      end else if (!mute_en_i) begin
         muted_o <= 1'b0;
      end else if (mute_req_i) begin
         muted_o <= 1'b1;
      end else if (done_i && addr_word) begin
         muted_o <= !hit;
      end else if (idle_i && !wake_addr_i) begin
         muted_o <= 1'b0;
      end
   end

   a_r7_mute_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_en_i |=> !muted_o);

   a_r10_no_plain_word_while_muted: assert property (@(posedge clk) disable iff (!rst_n)
      (muted_o && !is_addr_i) |-> !deliver_o);

endmodule

// File: rtl/uart_rx_mute.sv
module uart_rx_mute
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 9,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick_i,
   input  logic              en_i,
   input  logic              cfg_len9_i,
   input  logic              cfg_par_en_i,
   input  logic              cfg_par_odd_i,
   input  logic              cfg_mute_en_i,
   input  logic              cfg_wake_addr_i,
   input  logic [ADDR_W-1:0] cfg_node_i,
   input  logic              mute_req_i,
   input  logic              rx_ack_i,
   input  logic              ie_rx_i,
   input  logic              ie_par_i,
   output logic [DATA_W-1:0] data_o,
   output logic              rdy_o,
   output logic              par_err_o,
   output logic              frm_err_o,
   output logic              ovr_err_o,
   output logic              muted_o,
   output logic              irq_o
);

   if (ADDR_W > DATA_W - 2) begin : g_bad_addr
      $error("ADDR_W must leave room for the address flag and parity");
   end

   localparam logic [DATA_W-1:0] TOP_FULL  = DATA_W'(1) << (DATA_W - 1);
   localparam logic [DATA_W-1:0] TOP_SHORT = DATA_W'(1) << (DATA_W - 2);

   rx_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= '0;
      else if (!en_i) cfg_q <= '{len9: cfg_len9_i, par_en: cfg_par_en_i,
                                 par_odd: cfg_par_odd_i, wake_addr: cfg_wake_addr_i};
   end

   logic [DATA_W-1:0] word;
   logic              stop_ok, done, idle;

   uart_rx_sampler #(.OVS(OVS), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .tick_i     (tick_i),
      .rx_i       (rx_i),
      .len_full_i (cfg_q.len9),
      .word_o     (word),
      .stop_ok_o  (stop_ok),
      .done_o     (done),
      .idle_o     (idle)
   );

   logic [DATA_W-1:0] top_mask, addr_mask, clean;
   logic              par_bad, is_addr, deliver;

   always_comb begin
      top_mask  = cfg_q.len9 ? TOP_FULL : TOP_SHORT;
      clean     = cfg_q.par_en ? (word & ~top_mask) : word;
      addr_mask = cfg_q.par_en ? (top_mask >> 1) : top_mask;
      is_addr   = |(clean & addr_mask);
      par_bad   = cfg_q.par_en && ((^word) ^ cfg_q.par_odd);
   end

   uart_rx_mute_ctl #(.ADDR_W(ADDR_W)) u_mute (
      .clk         (clk),
      .rst_n       (rst_n),
      .mute_en_i   (cfg_mute_en_i),
      .wake_addr_i (cfg_q.wake_addr),
      .mute_req_i  (mute_req_i),
      .idle_i      (idle),
      .done_i      (done),
      .is_addr_i   (is_addr),
      .addr_i      (clean[ADDR_W-1:0]),
      .node_i      (cfg_node_i),
      .deliver_o   (deliver),
      .muted_o     (muted_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o    <= '0;
         rdy_o     <= 1'b0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
         ovr_err_o <= 1'b0;
      end else if (deliver && rdy_o && !rx_ack_i) begin
         ovr_err_o <= 1'b1;
      end else if (deliver) begin
         data_o    <= clean;
         rdy_o     <= 1'b1;
         par_err_o <= par_bad;
         frm_err_o <= !stop_ok;
         ovr_err_o <= 1'b0;
      end else if (rx_ack_i) begin
         rdy_o     <= 1'b0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
         ovr_err_o <= 1'b0;
      end
   end

   assign irq_o = (ie_rx_i && (rdy_o || ovr_err_o)) || (ie_par_i && par_err_o);

   a_r5_overrun_has_word: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_err_o |-> rdy_o);

   a_r5_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_o && !rx_ack_i) |=> $stable(data_o));

   a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_i) |-> $stable(cfg_q));

endmodule

// File: tb/sim_uart_rx_mute.sv
`timescale 1ns/1ps
module sim_uart_rx_mute;

   typedef struct packed {
      logic [8:0] d;
      logic       pe;
      logic       fe;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       tick;
   logic [1:0] dv = '0;
   logic       en = 0, len9 = 0, par_en = 0, par_odd = 0, mute_en = 0, wake_addr = 0;
   logic [3:0] node = '0;
   logic       mute_req = 0, ack = 0, ie_rx = 0, ie_par = 0;
   logic [8:0] data;
   logic       rdy, perr, ferr, ovr, muted, irq;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    auto_ack = 0;
   item_t exp_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) dv <= dv + 1'b1;
   assign tick = (dv == 2'd3);

   uart_rx_mute u0 (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .en_i(en),
      .cfg_len9_i(len9), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
      .cfg_mute_en_i(mute_en), .cfg_wake_addr_i(wake_addr), .cfg_node_i(node),
      .mute_req_i(mute_req), .rx_ack_i(ack), .ie_rx_i(ie_rx), .ie_par_i(ie_par),
      .data_o(data), .rdy_o(rdy), .par_err_o(perr), .frm_err_o(ferr),
      .ovr_err_o(ovr), .muted_o(muted), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bit_time(input logic v);
      rx = v;
      repeat (16) @(posedge tick);
      @(negedge clk);
   endtask

   task automatic wait_bits(input int n);
      repeat (n * 16) @(posedge tick);
      @(negedge clk);
   endtask

   task automatic send(input logic [8:0] v, input int nb, input logic stopb);
      bit_time(1'b0);
      for (int i = 0; i < nb; i++) bit_time(v[i]);
      bit_time(stopb);
      rx = 1'b1;
   endtask

   task automatic expect_word(input logic [8:0] d, input logic pe, input logic fe);
      exp_q.push_back('{d: d, pe: pe, fe: fe});
   endtask

   task automatic pulse_req();
      @(negedge clk) mute_req = 1'b1;
      @(negedge clk) mute_req = 1'b0;
   endtask

   task automatic manual_ack();
      @(negedge clk) ack = 1'b1;
      @(negedge clk) ack = 1'b0;
   endtask

   task automatic reconfig(input logic l9, input logic pen, input logic podd, input logic wk);
      @(negedge clk) en = 1'b0;
      len9 = l9; par_en = pen; par_odd = podd; wake_addr = wk;
      @(negedge clk) en = 1'b1;
      wait_bits(12);
   endtask

   // Monitor: pops the scoreboard each time a word is presented (R1, R3, R4)
   always @(negedge clk) begin
      if (ack) begin
         if (auto_ack) ack = 1'b0;
      end else if (auto_ack && rdy) begin
         if (exp_q.size() == 0) begin
            chk("R10 unexpected word delivered", {23'd0, data}, 32'h0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            chk("R1 data word", {23'd0, data}, {23'd0, e.d});
            chk("R3 parity flag", {31'd0, perr}, {31'd0, e.pe});
            chk("R4 framing flag", {31'd0, ferr}, {31'd0, e.fe});
         end
         ack = 1'b1;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset rdy", {31'd0, rdy}, 0);
      chk("R1 reset muted", {31'd0, muted}, 0);
      chk("R5 reset ovr", {31'd0, ovr}, 0);
      chk("R11 reset irq", {31'd0, irq}, 0);

      // R1: 8-bit frames
      auto_ack = 1;
      @(negedge clk) en = 1'b1;
      wait_bits(12);
      expect_word(9'h0A5, 0, 0); send(9'h0A5, 8, 1'b1);
      expect_word(9'h03C, 0, 0); send(9'h03C, 8, 1'b1);
      wait_bits(2);
      chk("R1 scoreboard drained", exp_q.size(), 0);

      // R2: short glitch
      rx = 1'b0; repeat (4) @(posedge tick); @(negedge clk); rx = 1'b1;
      wait_bits(3);
      chk("R2 glitch no word", {31'd0, rdy}, 0);
      expect_word(9'h05A, 0, 0); send(9'h05A, 8, 1'b1);
      wait_bits(1);

      // R12: disabled receiver
      @(negedge clk) en = 1'b0;
      send(9'h077, 8, 1'b1);
      wait_bits(1);
      chk("R12 no word while disabled", {31'd0, rdy}, 0);

      // R6: 9-bit accepted while disabled, parity change while enabled ignored
      reconfig(1, 0, 0, 0);
      par_en = 1'b1;
      expect_word(9'h1C3, 0, 0); send(9'h1C3, 9, 1'b1);
      expect_word(9'h0FF, 0, 0); send(9'h0FF, 9, 1'b1);
      wait_bits(1);
      chk("R6 late parity ignored", exp_q.size(), 0);

      // R3: 8-bit even, then odd, then 9-bit even
      reconfig(0, 1, 0, 0);
      expect_word(9'h003, 0, 0); send(9'h003, 8, 1'b1);
      expect_word(9'h001, 1, 0); send(9'h001, 8, 1'b1);
      expect_word(9'h003, 1, 0); send(9'h083, 8, 1'b1);
      reconfig(0, 1, 1, 0);
      expect_word(9'h001, 0, 0); send(9'h001, 8, 1'b1);
      reconfig(1, 1, 0, 0);
      expect_word(9'h0FF, 1, 0); send(9'h1FF, 9, 1'b1);
      expect_word(9'h07F, 0, 0); send(9'h17F, 9, 1'b1);
      wait_bits(1);
      chk("R3 parity words drained", exp_q.size(), 0);

      // R11: parity interrupt enable
      auto_ack = 0;
      ie_par = 1'b1;
      send(9'h1FF, 9, 1'b1);
      wait_bits(1);
      chk("R11 irq from parity error", {31'd0, irq}, 1);
      ie_par = 1'b0;
      @(negedge clk);
      chk("R11 irq masked", {31'd0, irq}, 0);
      manual_ack();
      @(negedge clk);
      chk("R5 ack clears parity flag", {31'd0, perr}, 0);

      // R4: low stop bit
      reconfig(0, 0, 0, 0);
      auto_ack = 1;
      expect_word(9'h042, 0, 1); send(9'h042, 8, 1'b0);
      wait_bits(3);
      chk("R4 framing word drained", exp_q.size(), 0);

      // R5: overrun, R11 data interrupt
      auto_ack = 0;
      ie_rx = 1'b1;
      send(9'h011, 8, 1'b1);
      send(9'h022, 8, 1'b1);
      wait_bits(1);
      chk("R5 rdy held", {31'd0, rdy}, 1);
      chk("R5 overrun flag", {31'd0, ovr}, 1);
      chk("R5 first word kept", {23'd0, data}, 32'h011);
      chk("R11 irq on data/overrun", {31'd0, irq}, 1);
      manual_ack();
      @(negedge clk);
      chk("R5 ack clears rdy", {31'd0, rdy}, 0);
      chk("R5 ack clears overrun", {31'd0, ovr}, 0);
      chk("R11 irq drops", {31'd0, irq}, 0);
      ie_rx = 1'b0;
      auto_ack = 1;

      // R7: mute request ignored without mute enable
      pulse_req();
      @(negedge clk);
      chk("R7 request ignored", {31'd0, muted}, 0);
      expect_word(9'h010, 0, 0); send(9'h010, 8, 1'b1);

      // R8, R10: idle-line wake
      mute_en = 1'b1;
      wait_bits(12);
      pulse_req();
      @(negedge clk);
      chk("R7 request mutes", {31'd0, muted}, 1);
      send(9'h044, 8, 1'b1);
      send(9'h045, 8, 1'b0);
      @(negedge clk);
      chk("R10 no rdy while muted", {31'd0, rdy}, 0);
      chk("R10 no framing flag while muted", {31'd0, ferr}, 0);
      chk("R8 still muted before idle", {31'd0, muted}, 1);
      wait_bits(12);
      chk("R8 woken by idle line", {31'd0, muted}, 0);
      expect_word(9'h046, 0, 0); send(9'h046, 8, 1'b1);
      wait_bits(1);

      // R9: address wake with node 5
      node = 4'h5;
      reconfig(0, 0, 0, 1);
      pulse_req();
      send(9'h033, 8, 1'b1);
      chk("R9 plain word dropped", {31'd0, muted}, 1);
      expect_word(9'h085, 0, 0); send(9'h085, 8, 1'b1);
      chk("R9 match wakes", {31'd0, muted}, 0);
      expect_word(9'h022, 0, 0); send(9'h022, 8, 1'b1);
      send(9'h087, 8, 1'b1);
      chk("R9 mismatch remutes", {31'd0, muted}, 1);
      send(9'h011, 8, 1'b1);
      wait_bits(1);
      chk("R9 only expected words", exp_q.size(), 0);
      chk("R10 nothing pending", {31'd0, rdy}, 0);
      @(negedge clk) mute_en = 1'b0;
      @(negedge clk);
      chk("R7 mute disable clears", {31'd0, muted}, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule